// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Controller

This block owns a table of two-word buffer descriptors that software fills and that a transmit datapath and a receive datapath consume. A programmable split index divides the table: entries below the split form the transmit ring, entries at or above it form the receive ring. The block keeps one pointer per ring. It decides when the descriptor under the transmit pointer may be offered for sending, and computes the length to send after padding and clamping. It writes back completion status, advances and wraps both rings, and gathers the transmit, receive and busy events into a maskable interrupt.

Each entry has a control word (word 0: length in bits 31:16, flags in bits 15:0) and a buffer address (word 1). The host reaches the table through a simple word port and reaches the control registers through a select/data port. Frame data and the line side are not handled here. The transmit side sees a valid/ready offer that carries the length and buffer address. The receive side presents a valid/ready frame summary and gets back the target buffer address.

The transmit offer is combinational and is withdrawn, not held, in any cycle with a host write or a receive frame on offer. Once `tx_ready` meets `tx_valid`, the descriptor is retired at that edge. The receive side asserts `rx_frm_ready` whenever reception is allowed and no host write is under way. Every accepted frame is either written to a descriptor or dropped, so the frame source never waits on the ring state.

Register selects: 0 mode (bit 0 receive enable, bit 1 transmit enable, bit 2 huge frames), 1 event source, 2 event mask, 3 split index, 4 frame limits (minimum in 31:16, maximum in 15:0).

Top module: `bd_ring_ctrl`

## Requirements
- R1: After reset the split index is 0x40, the transmit pointer is 0, the receive pointer is 0x40, the frame-limit register is 0x00400600, the event source is 0 and `irq` is low.
- R2: A write of 0x80 or more to the split index leaves it unchanged.
- R3: `tx_valid` is high only when transmit is enabled, the split is nonzero, control bit 15 (ready) of the entry under the transmit pointer is set and its length exceeds 4.
- R4: `tx_len` is the descriptor length raised to the minimum when control bit 12 (pad) is set, then lowered to the maximum unless huge frames are enabled.
- R5: On a transmit handshake the pointer goes to 0 if control bit 13 (wrap) is set, else it increments and goes to 0 once it reaches the split. Control bits 15 and 8:0 are cleared and the length and bits 14:9 are kept.
- R6: A frame accepted while bit 15 (empty) of the current receive entry is clear is dropped: event bit 4 is set, and the entry and the receive pointer are unchanged.
- R7: A frame accepted into an empty entry rewrites the control word. Bits 31:16 take the stored length (the frame length, limited to the maximum unless huge frames are on). Bit 15 clears, bits 14:9 are kept and bits 8:0 clear. Then bit 7 is set for a miss and bit 3 is set when huge frames are on and the length exceeds the maximum.
- R8: After a receive completion the pointer goes to the split when bit 13 (wrap) is set or the pointer is 0x7F, otherwise it increments.
- R9: A rising receive-enable reloads the receive pointer from the split, and a rising transmit-enable clears the transmit pointer.
- R10: A completed descriptor with bit 14 set raises event bit 2 (receive) or bit 0 (transmit). Writing the source clears the bits written as 1, and `irq` is the OR of source AND mask.
- R11: When a receive frame is on offer and reception is allowed, `tx_valid` is low: receive is served first.
- R12: `rx_frm_ready` is low while receive-enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| tbl_wr | input | 1 | host table write strobe |
| tbl_addr | input | 8 | host word address {entry, word} |
| tbl_wdata | input | 32 | host table write data |
| tbl_rdata | output | 32 | host table read data, one cycle after address |
| reg_wr | input | 1 | register write strobe |
| reg_sel | input | 3 | register select |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | selected register value |
| tx_valid | output | 1 | transmit offer |
| tx_ready | input | 1 | transmit side takes the offer |
| tx_len | output | 16 | length to send |
| tx_buf | output | 32 | buffer address to send from |
| rx_frm_valid | input | 1 | receive frame summary on offer |
| rx_frm_ready | output | 1 | frame summary accepted |
| rx_frm_len | input | 16 | received frame length |
| rx_frm_miss | input | 1 | address filter miss |
| rx_buf | output | 32 | buffer address of the current receive entry |
| tx_ptr | output | 7 | transmit pointer |
| rx_ptr | output | 7 | receive pointer |
| irq | output | 1 | interrupt request |

## Verification
On every cycle the assertions check several invariants. The split index stays inside the table, and each enable's rising edge moves its pointer. A drop raises the busy event and leaves the receive pointer in place. The offered and stored lengths respect the maximum when huge frames are off. The exact control words written back, the pad and clamp arithmetic, the wrap on the split versus the wrap bit versus the last entry, and receive priority over a pending transmit can only be seen through the bench's scenarios, which read the table back through the host port.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;
  // control word flag positions
  localparam int F_OWN   = 15;  // ready (tx) / empty (rx)
  localparam int F_IRQ   = 14;
  localparam int F_WRAP  = 13;
  localparam int F_PAD   = 12;
  localparam int F_MISS  = 7;
  localparam int F_LONG  = 3;
  localparam logic [15:0] TX_CLEAR = 16'h81FF;

  // mode register bits
  localparam int M_RX   = 0;
  localparam int M_TX   = 1;
  localparam int M_HUGE = 2;

  // event bits
  localparam int E_TX   = 0;
  localparam int E_RX   = 2;
  localparam int E_BUSY = 4;

  typedef enum logic [2:0] {
    SEL_MODE  = 3'd0,
    SEL_SRC   = 3'd1,
    SEL_MASK  = 3'd2,
    SEL_SPLIT = 3'd3,
    SEL_LIMIT = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/bd_table.sv
module bd_table #(
  parameter int ENTRIES = 128,
  localparam int PW = $clog2(ENTRIES),
  localparam int AW = PW + 1
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          eng_we,
  input  logic [PW-1:0] eng_idx,
  input  logic [31:0]   eng_wdata,
  input  logic [PW-1:0] tx_idx,
  input  logic [PW-1:0] rx_idx,
  output logic [31:0]   tx_ctl,
  output logic [31:0]   tx_bufp,
  output logic [31:0]   rx_ctl,
  output logic [31:0]   rx_bufp
);
  logic [31:0] mem [2*ENTRIES];

  always_ff @(posedge clk) begin
    if (host_we)     mem[host_addr]       <= host_wdata;
    else if (eng_we) mem[{eng_idx, 1'b0}] <= eng_wdata;
    host_rdata <= mem[host_addr];
  end

  assign tx_ctl  = mem[{tx_idx, 1'b0}];
  assign tx_bufp = mem[{tx_idx, 1'b1}];
  assign rx_ctl  = mem[{rx_idx, 1'b0}];
  assign rx_bufp = mem[{rx_idx, 1'b1}];
endmodule

// File: rtl/bd_tx_engine.sv
module bd_tx_engine
  import bd_ring_pkg::*;
#(
  parameter int ENTRIES = 128,
  localparam int PW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          huge,
  input  logic [PW:0]   split,
  input  logic [15:0]   min_len,
  input  logic [15:0]   max_len,
  input  logic [PW-1:0] ptr,
  input  logic [31:0]   ctl,
  output logic          offer,
  output logic [15:0]   len,
  output logic [PW-1:0] nxt_ptr,
  output logic [31:0]   done_ctl,
  output logic          irq_req
);
  logic [15:0] dlen, padded;
  logic [PW:0] inc;

  assign dlen  = ctl[31:16];
  assign offer = en && (split != '0) && ctl[F_OWN] && (dlen > 16'd4);

  always_comb begin
    padded = (ctl[F_PAD] && dlen < min_len) ? min_len : dlen;
    len    = (!huge && padded > max_len) ? max_len : padded;
  end

  assign inc = {1'b0, ptr} + {{PW{1'b0}}, 1'b1};
  always_comb begin
    if (ctl[F_WRAP] || inc >= split) nxt_ptr = '0;
    else                             nxt_ptr = inc[PW-1:0];
  end

  assign done_ctl = {ctl[31:16], ctl[15:0] & ~TX_CLEAR};
  assign irq_req  = ctl[F_IRQ];

  p_len_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (offer && !huge) |-> (len <= max_len));
endmodule

// File: rtl/bd_rx_engine.sv
module bd_rx_engine
  import bd_ring_pkg::*;
#(
  parameter int ENTRIES = 128,
  localparam int PW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          huge,
  input  logic [PW:0]   split,
  input  logic [15:0]   max_len,
  input  logic [PW-1:0] ptr,
  input  logic [15:9]   ctl_hi,
  input  logic [15:0]   frm_len,
  input  logic          frm_miss,
  output logic          has_room,
  output logic [PW-1:0] nxt_ptr,
  output logic [31:0]   done_ctl,
  output logic          irq_req
);
  localparam logic [PW-1:0] LAST = PW'(ENTRIES - 1);
  logic [15:0] keep_len;
  logic        too_long;
  logic [8:0]  status;

  assign has_room = ctl_hi[F_OWN];
  assign too_long = huge && (frm_len > max_len);
  assign keep_len = (!huge && frm_len > max_len) ? max_len : frm_len;

  always_comb begin
    status         = '0;
    status[F_MISS] = frm_miss;
    status[F_LONG] = too_long;
  end

  assign done_ctl = {keep_len, 1'b0, ctl_hi[14:9], status};
  assign irq_req  = ctl_hi[F_IRQ];

  always_comb begin
    if (ctl_hi[F_WRAP] || ptr == LAST) nxt_ptr = split[PW-1:0];
    else                               nxt_ptr = ptr + 1'b1;
  end

  p_store_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !huge |-> (done_ctl[31:16] <= max_len));
endmodule

// File: rtl/bd_ring_ctrl.sv
module bd_ring_ctrl
  import bd_ring_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter logic [31:0] SPLIT_RST = 32'h40,
  parameter logic [31:0] LIMIT_RST = 32'h0040_0600,
  localparam int PW = $clog2(ENTRIES),
  localparam int AW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_wr,
  input  logic [AW-1:0] tbl_addr,
  input  logic [31:0]   tbl_wdata,
  output logic [31:0]   tbl_rdata,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [15:0]   tx_len,
  output logic [31:0]   tx_buf,
  input  logic          rx_frm_valid,
  output logic          rx_frm_ready,
  input  logic [15:0]   rx_frm_len,
  input  logic          rx_frm_miss,
  output logic [31:0]   rx_buf,
  output logic [PW-1:0] tx_ptr,
  output logic [PW-1:0] rx_ptr,
  output logic          irq
);
  logic [2:0]  mode;
  logic [4:0]  src, mask;
  logic [PW:0] split;
  logic [31:0] limits;

  logic [31:0] tx_ctl, rx_ctl, tx_done, rx_done;
  logic [PW-1:0] tx_nxt, rx_nxt;
  logic tx_offer, tx_irq, rx_room, rx_irq;
  logic host_busy, rx_allowed, rx_take, rx_fill, rx_drop, tx_fire;
  logic eng_we;
  logic [PW-1:0] eng_idx;
  logic [31:0] eng_wdata;
  logic [4:0] ev_set, ev_clr;

  bd_table #(.ENTRIES(ENTRIES)) u_table (
    .clk(clk), .host_we(tbl_wr), .host_addr(tbl_addr), .host_wdata(tbl_wdata),
    .host_rdata(tbl_rdata), .eng_we(eng_we), .eng_idx(eng_idx),
    .eng_wdata(eng_wdata), .tx_idx(tx_ptr), .rx_idx(rx_ptr),
    .tx_ctl(tx_ctl), .tx_bufp(tx_buf), .rx_ctl(rx_ctl), .rx_bufp(rx_buf)
  );

  bd_tx_engine #(.ENTRIES(ENTRIES)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(mode[M_TX]), .huge(mode[M_HUGE]),
    .split(split), .min_len(limits[31:16]), .max_len(limits[15:0]),
    .ptr(tx_ptr), .ctl(tx_ctl), .offer(tx_offer), .len(tx_len),
    .nxt_ptr(tx_nxt), .done_ctl(tx_done), .irq_req(tx_irq)
  );

  bd_rx_engine #(.ENTRIES(ENTRIES)) u_rx (
    .clk(clk), .rst_n(rst_n), .huge(mode[M_HUGE]), .split(split),
    .max_len(limits[15:0]), .ptr(rx_ptr), .ctl_hi(rx_ctl[15:9]),
    .frm_len(rx_frm_len), .frm_miss(rx_frm_miss), .has_room(rx_room),
    .nxt_ptr(rx_nxt), .done_ctl(rx_done), .irq_req(rx_irq)
  );

  // arbitration: host access first, then receive, then transmit
  assign host_busy    = tbl_wr || reg_wr;
  assign rx_allowed   = mode[M_RX] && (split < AW'(ENTRIES));
  assign rx_frm_ready = rx_allowed && !host_busy;
  assign rx_take      = rx_frm_valid && rx_frm_ready;
  assign rx_fill      = rx_take && rx_room;
  assign rx_drop      = rx_take && !rx_room;
  assign tx_valid     = tx_offer && !host_busy && !(rx_frm_valid && rx_allowed);
  assign tx_fire      = tx_valid && tx_ready;

  assign eng_we    = rx_fill || tx_fire;
  assign eng_idx   = rx_fill ? rx_ptr : tx_ptr;
  assign eng_wdata = rx_fill ? rx_done : tx_done;

  always_comb begin
    ev_set         = '0;
    ev_set[E_TX]   = tx_fire && tx_irq;
    ev_set[E_RX]   = rx_fill && rx_irq;
    ev_set[E_BUSY] = rx_drop;
    ev_clr = (reg_wr && reg_sel == SEL_SRC) ? reg_wdata[4:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= '0;
      src    <= '0;
      mask   <= '0;
      split  <= SPLIT_RST[PW:0];
      limits <= LIMIT_RST;
      tx_ptr <= '0;
      rx_ptr <= SPLIT_RST[PW-1:0];
    end else begin
      src <= (src & ~ev_clr) | ev_set;
      if (reg_wr) begin
        case (reg_sel)
          SEL_MODE: begin
            mode <= reg_wdata[2:0];
            if (reg_wdata[M_RX] && !mode[M_RX]) rx_ptr <= split[PW-1:0];
            if (reg_wdata[M_TX] && !mode[M_TX]) tx_ptr <= '0;
          end
          SEL_MASK:  mask <= reg_wdata[4:0];
          SEL_SPLIT: if (reg_wdata < 32'(ENTRIES)) split <= reg_wdata[PW:0];
          SEL_LIMIT: limits <= reg_wdata;
          default: ;
        endcase
      end
      if (rx_fill) rx_ptr <= rx_nxt;
      if (tx_fire) tx_ptr <= tx_nxt;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_MODE:  reg_rdata = {29'd0, mode};
      SEL_SRC:   reg_rdata = {27'd0, src};
      SEL_MASK:  reg_rdata = {27'd0, mask};
      SEL_SPLIT: reg_rdata = {{(31-PW){1'b0}}, split};
      SEL_LIMIT: reg_rdata = limits;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = |(src & mask);

  p_split_inside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    split < AW'(ENTRIES));
  p_tx_rise_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode[M_TX]) |-> tx_ptr == '0);
  p_rx_rise_reloads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode[M_RX]) |-> rx_ptr == split[PW-1:0]);
  p_drop_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> src[E_BUSY]);
  p_drop_holds_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> rx_ptr == $past(rx_ptr));
endmodule

// File: tb/bd_ring_ctrl_tb.sv
module bd_ring_ctrl_tb;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic tbl_wr = 0, reg_wr = 0, tx_ready = 0, rx_frm_valid = 0, rx_frm_miss = 0;
  logic [7:0] tbl_addr = 0;
  logic [31:0] tbl_wdata = 0, reg_wdata = 0;
  logic [2:0] reg_sel = 0;
  logic [15:0] rx_frm_len = 0;
  logic [31:0] tbl_rdata, reg_rdata, tx_buf, rx_buf;
  logic tx_valid, rx_frm_ready, irq;
  logic [15:0] tx_len;
  logic [6:0] tx_ptr, rx_ptr;

  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;
  logic got_ready;

  always #(PERIOD/2) clk = ~clk;

  bd_ring_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_len(tx_len), .tx_buf(tx_buf),
    .rx_frm_valid(rx_frm_valid), .rx_frm_ready(rx_frm_ready),
    .rx_frm_len(rx_frm_len), .rx_frm_miss(rx_frm_miss), .rx_buf(rx_buf),
    .tx_ptr(tx_ptr), .rx_ptr(rx_ptr), .irq(irq)
  );

  // {len, pad, huge, expect valid, expected tx_len}; limits 0x40 / 0x600
  localparam logic [34:0] VEC [7] = '{
    {16'h0010, 1'b1, 1'b0, 1'b1, 16'h0040},
    {16'h0010, 1'b0, 1'b0, 1'b1, 16'h0010},
    {16'h0700, 1'b0, 1'b0, 1'b1, 16'h0600},
    {16'h0700, 1'b0, 1'b1, 1'b1, 16'h0700},
    {16'h0040, 1'b1, 1'b0, 1'b1, 16'h0040},
    {16'h0005, 1'b0, 1'b0, 1'b1, 16'h0005},
    {16'h0004, 1'b1, 1'b0, 1'b0, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = val;
    @(negedge clk); reg_wr = 0; #1;
  endtask

  task automatic rd_reg(input logic [2:0] sel, output logic [31:0] val);
    reg_sel = sel; #1; val = reg_rdata;
  endtask

  task automatic wr_tbl(input logic [6:0] ent, input logic w, input logic [31:0] val);
    @(negedge clk); tbl_wr = 1; tbl_addr = {ent, w}; tbl_wdata = val;
    @(negedge clk); tbl_wr = 0; #1;
  endtask

  task automatic rd_tbl(input logic [6:0] ent, input logic w, output logic [31:0] val);
    @(negedge clk); tbl_addr = {ent, w};
    @(negedge clk); #1; val = tbl_rdata;
  endtask

  task automatic tx_take();
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0; #1;
  endtask

  task automatic rx_offer(input logic [15:0] len, input logic miss);
    @(negedge clk); rx_frm_valid = 1; rx_frm_len = len; rx_frm_miss = miss;
    #1; got_ready = rx_frm_ready;
    @(negedge clk); rx_frm_valid = 0; #1;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R1 reset state
    rd_reg(3'd3, rv); chk("R1 split", rv, 32'h40);
    rd_reg(3'd4, rv); chk("R1 limits", rv, 32'h0040_0600);
    rd_reg(3'd1, rv); chk("R1 source", rv, 0);
    chk("R1 tx_ptr", 32'(tx_ptr), 0);
    chk("R1 rx_ptr", 32'(rx_ptr), 32'h40);
    chk("R1 irq", 32'(irq), 0);
    // R2 oversize split ignored
    wr_reg(3'd3, 32'h90);
    rd_reg(3'd3, rv); chk("R2 split kept", rv, 32'h40);

    wr_reg(3'd2, 32'h15);
    wr_reg(3'd0, 32'h2);
    // R3/R4 length vectors on entry 0 with wrap set
    for (int i = 0; i < 7; i++) begin
      wr_reg(3'd0, {29'd0, VEC[i][17], 2'b10});
      wr_tbl(7'd0, 1'b1, 32'h1000 + i);
      wr_tbl(7'd0, 1'b0, {VEC[i][34:19], 3'b101, VEC[i][18], 12'h000});
      chk("R3 tx_valid", 32'(tx_valid), 32'(VEC[i][16]));
      if (VEC[i][16]) begin
        chk("R4 tx_len", 32'(tx_len), 32'(VEC[i][15:0]));
        chk("R4 tx_buf", tx_buf, 32'h1000 + i);
        tx_take();
        chk("R5 wrap bit to 0", 32'(tx_ptr), 0);
      end
    end
    wr_reg(3'd0, 32'h2);
    wr_tbl(7'd0, 1'b0, 32'h0020_2000);
    chk("R3 not ready", 32'(tx_valid), 0);

    // R5 advance and split wrap, status clearing, R10 event
    wr_reg(3'd3, 32'h2);
    wr_tbl(7'd0, 1'b0, 32'h0020_D9FF);
    chk("R4 padded", 32'(tx_len), 32'h40);
    tx_take();
    chk("R5 advance", 32'(tx_ptr), 1);
    rd_tbl(7'd0, 1'b0, rv); chk("R5 cleared bits", rv, 32'h0020_5800);
    rd_reg(3'd1, rv); chk("R10 tx event", rv, 32'h1);
    chk("R10 irq high", 32'(irq), 1);
    wr_tbl(7'd1, 1'b0, 32'h0010_8000);
    tx_take();
    chk("R5 split wrap", 32'(tx_ptr), 0);
    wr_reg(3'd1, 32'h1);
    rd_reg(3'd1, rv); chk("R10 w1c", rv, 0);
    chk("R10 irq low", 32'(irq), 0);

    // R9 transmit enable edge
    wr_tbl(7'd0, 1'b0, 32'h0010_8000);
    tx_take();
    chk("R9 pre", 32'(tx_ptr), 1);
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd0, 32'h2);
    chk("R9 tx rise", 32'(tx_ptr), 0);

    // R12 receive disabled
    rx_offer(16'h30, 1'b0);
    chk("R12 ready low", 32'(got_ready), 0);
    wr_reg(3'd0, 32'h3);
    chk("R9 rx rise", 32'(rx_ptr), 2);

    // R6 drop on full entry
    wr_tbl(7'd2, 1'b0, 32'h0);
    rx_offer(16'h30, 1'b0);
    chk("R6 accepted", 32'(got_ready), 1);
    rd_reg(3'd1, rv); chk("R6 busy", rv, 32'h10);
    chk("R6 ptr held", 32'(rx_ptr), 2);
    rd_tbl(7'd2, 1'b0, rv); chk("R6 entry kept", rv, 0);
    wr_reg(3'd1, 32'h10);

    // R7/R8 completion
    wr_tbl(7'd2, 1'b0, 32'h0000_C1FF);
    wr_tbl(7'd2, 1'b1, 32'hABCD_0000);
    chk("R7 rx_buf", rx_buf, 32'hABCD_0000);
    rx_offer(16'h30, 1'b1);
    rd_tbl(7'd2, 1'b0, rv); chk("R7 word", rv, 32'h0030_4080);
    chk("R8 advance", 32'(rx_ptr), 3);
    rd_reg(3'd1, rv); chk("R10 rx event", rv, 32'h4);
    wr_reg(3'd1, 32'h4);

    // R8 last entry wrap, R7 clamp and too-long
    wr_reg(3'd3, 32'h7F);
    wr_reg(3'd0, 32'h2);
    wr_reg(3'd0, 32'h3);
    chk("R9 reload", 32'(rx_ptr), 32'h7F);
    wr_tbl(7'h7F, 1'b0, 32'h0000_8000);
    rx_offer(16'h700, 1'b0);
    rd_tbl(7'h7F, 1'b0, rv); chk("R7 clamped", rv, 32'h0600_0000);
    chk("R8 last wrap", 32'(rx_ptr), 32'h7F);
    wr_reg(3'd0, 32'h7);
    wr_tbl(7'h7F, 1'b0, 32'h0000_A000);
    rx_offer(16'h700, 1'b0);
    rd_tbl(7'h7F, 1'b0, rv); chk("R7 huge long", rv, 32'h0700_2008);

    // R11 receive priority
    wr_reg(3'd0, 32'h3);
    wr_tbl(7'd0, 1'b0, 32'h0010_8000);
    chk("R11 tx offered", 32'(tx_valid), 1);
    @(negedge clk); rx_frm_valid = 1; rx_frm_len = 16'h20; #1;
    chk("R11 tx withdrawn", 32'(tx_valid), 0);
    chk("R11 rx served", 32'(rx_frm_ready), 1);
    @(negedge clk); rx_frm_valid = 0; #1;
    chk("R11 tx back", 32'(tx_valid), 1);

    // R3 split zero
    wr_reg(3'd3, 32'h0);
    chk("R3 split zero", 32'(tx_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule